// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits between a CAN bit sampler and a frame parser. The sampler hands it one bus bit per strobe. The block keeps a short history of the raw bits it has received in the current frame. Stuff bits stay in that history. From this history it decides whether each new bit is a stuff bit. Stuff bits are reported on their own strobe and never reach the frame-bit stream. Every other bit is forwarded with its position in the frame. The start-of-frame bit has position 0. Stuff bits do not advance the position.

The parser controls the block with three inputs. `frame_start` opens a frame and clears the history. `frame_end` closes it. `stuff_limit` tells the block where stuffing stops. The parser keeps `stuff_limit` at its all-ones value until it has decoded the data length, and then lowers it to the index of the last data bit. Stuff checking stays active only while the number of frame bits already forwarded is no larger than `stuff_limit + 16`. Once a bit arrives past that point, checking stays off for the rest of the frame, which covers the delimiter, acknowledge and end-of-frame region. If six equal raw bits arrive while checking is active, the block raises a one-cycle `stuff_err`.

A three-state sequencer controls the block. The states are:
- **IDLE**: no frame is open, and all bits are ignored.
- **LIVE**: a frame is open and stuff checking is active.
- **PASS**: a frame is open and stuff checking is off.

Its transitions are:
- **open**: IDLE→LIVE on `frame_start`.
- **restart**: LIVE or PASS→LIVE on `frame_start`.
- **tail**: LIVE→PASS on a bit that arrives beyond the limit.
- **close**: LIVE or PASS→IDLE on `frame_end`.

`frame_end` takes priority over `frame_start`. All outputs are registered and appear one clock after the input strobe.

Top module: `can_destuff`

## Requirements
- R1: While `rst_n` is low, and at the first check after reset, `frame_vld`, `stuff_vld` and `stuff_err` are 0.
- R2: A `bit_vld` in IDLE produces no output strobe. So does a `bit_vld` in the same cycle as `frame_end`. If `frame_end` and `frame_start` are both high, the block goes to IDLE.
- R3: Each accepted bit produces exactly one strobe in the next cycle. `out_bit` equals the input bit. Frame bits get `out_idx` values 0, 1, 2, … in order. A bit presented together with `frame_start` is accepted as the first bit, with index 0.
- R4: A bit is a stuff bit when checking is active, the five raw bits before it in this frame are all equal, and it has the opposite value. For a stuff bit, the block pulses `stuff_vld` instead of `frame_vld`, and `out_idx` shows the index the next frame bit will receive.
- R5: A stuff bit counts as a raw bit in the history. It can therefore start the run that makes a later bit a stuff bit.
- R6: `frame_start` clears the history. No bit is treated as stuff, and no error is raised, until five raw bits of the new frame have been received.
- R7: Checking is active for a bit only if the number of frame bits forwarded so far in the frame is at most `stuff_limit + 16`. After the first accepted bit that fails this test, checking stays off until the next `frame_start`.
- R8: When checking is active and a bit equals the five equal raw bits before it, `stuff_err` pulses for one cycle together with `frame_vld`. The bit is still forwarded as a frame bit.
- R9: `frame_vld` and `stuff_vld` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe: a sampled bus bit is present |
| bit_val | input | 1 | Sampled bus bit value (0 dominant) |
| frame_start | input | 1 | Opens a frame and clears the history |
| frame_end | input | 1 | Closes the frame (priority over start) |
| stuff_limit | input | IDX_W | Last-data-bit index from the parser |
| frame_vld | output | 1 | Strobe: forwarded frame bit |
| stuff_vld | output | 1 | Strobe: stuff bit removed |
| out_bit | output | 1 | Value of the bit just strobed |
| out_idx | output | IDX_W | Frame-bit index of the strobed bit |
| stuff_err | output | 1 | Six equal raw bits while checking was active |

## Verification
The hardest cases to reach are at the edges of stuff checking. One is a stuff candidate that arrives exactly at frame-bit count `stuff_limit + 16`. Another is a candidate one bit later, which must be forwarded as a plain frame bit. The bench reaches both with a low limit. It pads the frame with alternating bits, which can never form a stuff pattern, until the count is exactly right, and then builds a run of five. A second hard case is a run that straddles a stuff bit or a frame restart. Directed sequences cover these. Long random frames with a strong bias toward repeated bits then produce many stuff and error events. A reference model in the bench uses a queue and compares the outputs on every clock.

// File: rtl/can_destuff_pkg.sv
`timescale 1ns/1ps
package can_destuff_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LIVE = 2'd1,
        SEQ_PASS = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cd_history.sv
`timescale 1ns/1ps
// Raw-bit history: the last RUN_LEN received bits, stuff bits included.
module cd_history #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift,
    input  logic din,
    output logic primed,
    output logic run_eq,
    output logic last_bit
);
    localparam int FILL_W = $clog2(RUN_LEN + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(RUN_LEN);

    logic [RUN_LEN-1:0] hist;
    logic [FILL_W-1:0]  fill;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            fill <= '0;
        end else if (clr) begin
            hist <= shift ? {{(RUN_LEN-1){1'b0}}, din} : '0;
            fill <= shift ? FILL_W'(1) : '0;
        end else if (shift) begin
            hist <= {hist[RUN_LEN-2:0], din};
            if (fill != FILL_FULL) begin
                fill <= fill + FILL_W'(1);
            end
        end
    end

    always_comb begin
        primed   = (fill == FILL_FULL);
        run_eq   = (&hist) | ~(|hist);
        last_bit = hist[0];
    end

endmodule

// File: rtl/cd_seq.sv
`timescale 1ns/1ps
// Frame sequencer: frame open/close, stuffing window, frame-bit counter.
module cd_seq
    import can_destuff_pkg::*;
#(
    parameter int IDX_W      = 10,
    parameter int STUFF_TAIL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             bit_vld,
    input  logic             is_stuff,
    input  logic [IDX_W-1:0] stuff_limit,
    output logic             accept,
    output logic             live,
    output logic [IDX_W-1:0] cur_idx
);
    localparam int LIM_W = IDX_W + 1;

    seq_state_e       state, state_nx;
    logic [IDX_W-1:0] cnt;
    logic             over;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // frame-bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (frame_end) begin
            cnt <= '0;
        end else if (frame_start) begin
            cnt <= (accept && !is_stuff) ? IDX_W'(1) : '0;
        end else if (accept && !is_stuff) begin
            cnt <= cnt + IDX_W'(1);
        end
    end

    // outputs of the sequencer
    always_comb begin
        cur_idx = frame_start ? '0 : cnt;
        over    = LIM_W'(cur_idx) > (LIM_W'(stuff_limit) + LIM_W'(STUFF_TAIL));
        accept  = bit_vld && !frame_end && (frame_start || state != SEQ_IDLE);
        live    = (frame_start || state == SEQ_LIVE) && !over;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: begin
                if (frame_start && !frame_end) state_nx = SEQ_LIVE;    // open
            end
            SEQ_LIVE: begin
                if (frame_end)              state_nx = SEQ_IDLE;       // close
                else if (frame_start)       state_nx = SEQ_LIVE;       // restart
                else if (accept && over)    state_nx = SEQ_PASS;       // tail
            end
            SEQ_PASS: begin
                if (frame_end)              state_nx = SEQ_IDLE;       // close
                else if (frame_start)       state_nx = SEQ_LIVE;       // restart
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

endmodule

// File: rtl/can_destuff.sv
`timescale 1ns/1ps
// CAN bit destuffer: splits sampled bits into frame bits and stuff bits.
module can_destuff #(
    parameter int IDX_W      = 10,
    parameter int RUN_LEN    = 5,
    parameter int STUFF_TAIL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [IDX_W-1:0] stuff_limit,
    output logic             frame_vld,
    output logic             stuff_vld,
    output logic             out_bit,
    output logic [IDX_W-1:0] out_idx,
    output logic             stuff_err
);
    logic             accept, live;
    logic [IDX_W-1:0] cur_idx;
    logic             h_primed, h_run_eq, h_last;
    logic             run_hit, stuff_hit, err_hit;

    cd_history #(.RUN_LEN(RUN_LEN)) i_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (frame_start || frame_end),
        .shift    (accept),
        .din      (bit_val),
        .primed   (h_primed),
        .run_eq   (h_run_eq),
        .last_bit (h_last)
    );

    cd_seq #(.IDX_W(IDX_W), .STUFF_TAIL(STUFF_TAIL)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .bit_vld     (bit_vld),
        .is_stuff    (stuff_hit),
        .stuff_limit (stuff_limit),
        .accept      (accept),
        .live        (live),
        .cur_idx     (cur_idx)
    );

    // history of a previous frame is void when a new one opens this cycle
    always_comb begin
        run_hit   = accept && live && h_primed && !frame_start && h_run_eq;
        stuff_hit = run_hit && (bit_val != h_last);
        err_hit   = run_hit && (bit_val == h_last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_vld <= 1'b0;
            stuff_vld <= 1'b0;
            stuff_err <= 1'b0;
            out_bit   <= 1'b0;
            out_idx   <= '0;
        end else begin
            frame_vld <= accept && !stuff_hit;
            stuff_vld <= stuff_hit;
            stuff_err <= err_hit;
            if (accept) begin
                out_bit <= bit_val;
                out_idx <= cur_idx;
            end
        end
    end

endmodule

// File: rtl/cd_destuff_chk.sv
`timescale 1ns/1ps
module cd_destuff_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_vld,
    input logic             frame_start,
    input logic             frame_end,
    input logic             frame_vld,
    input logic             stuff_vld,
    input logic [IDX_W-1:0] out_idx,
    input logic             stuff_err
);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_vld && stuff_vld));

    // R8
    err_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> frame_vld);

    // R2
    end_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !(frame_vld || stuff_vld));

    // R3
    first_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && bit_vld && !frame_end) |=> (frame_vld && out_idx == '0));

    // R3
    strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld || stuff_vld) |-> $past(bit_vld));

endmodule

bind can_destuff cd_destuff_chk #(.IDX_W(IDX_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_vld     (bit_vld),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_vld   (frame_vld),
    .stuff_vld   (stuff_vld),
    .out_idx     (out_idx),
    .stuff_err   (stuff_err)
);

// File: tb/test_can_destuff.sv
`timescale 1ns/1ps
module test_can_destuff;
    localparam int IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_vld = 1'b0;
    logic             bit_val = 1'b0;
    logic             frame_start = 1'b0;
    logic             frame_end = 1'b0;
    logic [IDX_W-1:0] stuff_limit = '1;
    logic             frame_vld, stuff_vld, out_bit, stuff_err;
    logic [IDX_W-1:0] out_idx;

    can_destuff #(.IDX_W(IDX_W)) i_can_destuff (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
        .frame_start(frame_start), .frame_end(frame_end), .stuff_limit(stuff_limit),
        .frame_vld(frame_vld), .stuff_vld(stuff_vld), .out_bit(out_bit),
        .out_idx(out_idx), .stuff_err(stuff_err)
    );

    always #2.5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    bit q[$];
    int m_cnt = 0;
    bit m_in  = 1'b0;
    bit m_off = 1'b0;

    function automatic bit five_equal();
        if (q.size() < 5) return 1'b0;
        for (int k = q.size() - 5; k < q.size(); k++)
            if (q[k] != q[q.size() - 1]) return 1'b0;
        return 1'b1;
    endfunction

    // one clock: drive at negedge, model, sample after posedge
    task automatic step(input bit st, input bit en, input bit v, input bit b, input string tag);
        bit acc, live, run, stf, err, ok;
        int idx;
        frame_start = st; frame_end = en; bit_vld = v; bit_val = b;
        if (st) begin q.delete(); m_cnt = 0; m_off = 1'b0; end
        acc  = v && !en && (st || m_in);
        live = !m_off && (m_cnt <= int'(stuff_limit) + 16);
        run  = five_equal();
        stf  = acc && live && run && (b != q[q.size() - 1]);
        err  = acc && live && run && (b == q[q.size() - 1]);
        idx  = m_cnt;
        if (acc) begin
            if (!live) m_off = 1'b1;
            q.push_back(b);
            if (q.size() > 6) void'(q.pop_front());
            if (!stf) m_cnt++;
        end
        if (en) begin m_in = 1'b0; q.delete(); m_cnt = 0; m_off = 1'b0; end
        else if (st) m_in = 1'b1;
        @(posedge clk); #1;
        ok = (frame_vld == (acc && !stf)) && (stuff_vld == stf) && (stuff_err == err) &&
             (!acc || (out_bit == b && out_idx == IDX_W'(idx)));
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got f=%0b s=%0b e=%0b bit=%0b idx=%0d expected f=%0b s=%0b e=%0b bit=%0b idx=%0d",
                     tag, frame_vld, stuff_vld, stuff_err, out_bit, out_idx,
                     acc && !stf, stf, err, b, idx);
        end
        @(negedge clk);
        frame_start = 1'b0; frame_end = 1'b0; bit_vld = 1'b0;
    endtask

    task automatic bits_alt(input int n, input bit first, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 1, first ^ k[0], tag);
    endtask

    task automatic bits_run(input int n, input bit val, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 1, val, tag);
    endtask

    task automatic rand_frame(input int n, input string tag);
        bit prev = 1'b0;
        step(1, 0, 1, 1'b0, tag);
        for (int k = 0; k < n; k++) begin
            if (($urandom % 5) == 0) prev = ~prev;
            step(0, 0, ($urandom % 8) != 0, prev, tag);
        end
        step(0, 1, 0, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        n_chk++;
        if (frame_vld || stuff_vld || stuff_err) begin
            n_fail++;
            $display("FAIL R1: got f=%0b s=%0b e=%0b expected 0 0 0", frame_vld, stuff_vld, stuff_err);
        end
        rst_n = 1'b1;
        @(negedge clk);
        step(0, 0, 0, 1'b0, "R1");

        // R2: bits before any frame are ignored
        bits_run(3, 1'b0, "R2");
        // R3 / R4 / R5: open with SOF, five zeros then stuff 1, then the stuff bit starts a run of ones
        step(1, 0, 1, 1'b0, "R3");
        bits_run(4, 1'b0, "R3");
        step(0, 0, 1, 1'b1, "R4");
        bits_run(4, 1'b1, "R5");
        step(0, 0, 1, 1'b0, "R5");
        // R8: six equal bits raise the error
        bits_run(4, 1'b0, "R8");
        step(0, 0, 1, 1'b0, "R8");
        bits_run(2, 1'b0, "R8");
        // R6: restart mid-frame after a run of ones; the old run must not count
        bits_run(5, 1'b1, "R6");
        step(1, 0, 1, 1'b0, "R6");
        bits_run(3, 1'b0, "R6");
        step(0, 0, 1, 1'b1, "R6");
        // R2: close, then bits ignored, then end+start+bit together
        step(0, 1, 1, 1'b0, "R2");
        bits_run(3, 1'b1, "R2");
        step(1, 1, 1, 1'b0, "R2");
        step(0, 0, 1, 1'b0, "R2");

        // R7: limit 2 -> checking while forwarded count <= 18
        stuff_limit = IDX_W'(2);
        step(1, 0, 1, 1'b0, "R7");
        bits_alt(13, 1'b1, "R7");          // idx 1..13, idx13 = 1
        bits_run(4, 1'b1, "R7");           // idx 14..17
        step(0, 0, 1, 1'b0, "R7");         // candidate at count 18: stuffed
        step(0, 1, 0, 1'b0, "R7");
        step(1, 0, 1, 1'b0, "R7");
        bits_alt(14, 1'b1, "R7");          // idx 1..14, idx14 = 0
        bits_run(4, 1'b0, "R7");           // idx 15..18
        step(0, 0, 1, 1'b1, "R7");         // candidate at count 19: frame bit
        bits_run(6, 1'b1, "R7");           // checking stays off: no error
        step(0, 1, 0, 1'b0, "R7");

        // random frames with long runs
        stuff_limit = '1;
        rand_frame(150, "R4");
        rand_frame(150, "R8");
        stuff_limit = IDX_W'(40);
        rand_frame(120, "R7");
        stuff_limit = '1;
        rand_frame(200, "R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule